// File: doc/BRIEF.md
# Receive FIFO with Overrun Lock

This block is a small circular receive buffer that sits between a serial receiver and a CPU register port. The serial side pushes one byte per write strobe at the write pointer. The CPU reads the byte at the read pointer, which is always visible on `rd_data`, and a read strobe advances that pointer. Both pointers only count upward and wrap from the last entry back to entry 0. Reads are not gated by the empty state, so reading an empty buffer still moves the read pointer.

An overrun is recorded when a serial write leaves the write pointer equal to the read pointer. The overrun flag is sticky and locks the write side. While it is set, serial bytes are dropped and the write pointer does not move. A strobe from the status-register write decode clears the flag. Clearing a set flag does not resume from the old position: it empties the buffer by returning both pointers to entry 0.

The CPU may also store a byte directly at the read pointer without moving either pointer. A debug-halt input stops reads from advancing. An enable input held low forces both pointers to 0. A flush input, raised on entry to a low-power state, also empties the buffer but leaves the overrun flag unchanged. None of these clears the stored bytes.

Top module: `rx_fifo_ovr_lock`

## Requirements
- R1: After reset both pointers are 0, `not_empty` is 0 and `overrun` is 0.
- R2: The buffer holds DEPTH (default 12) bytes of WIDTH (default 8) bits. An accepted serial write stores `ser_data` at the write pointer, and the pointer then increments, wrapping from DEPTH-1 to 0.
- R3: `rd_data` always shows the entry at the read pointer. A CPU read strobe advances the read pointer by one with the same wrap, whether or not the buffer is empty.
- R4: `not_empty` is 1 exactly when the write pointer differs from the read pointer and `overrun` is 0.
- R5: `overrun` becomes 1 when an accepted serial write leaves the write pointer equal to the read pointer. The read pointer used here is its value after any read in the same cycle.
- R6: While `overrun` is 1, serial writes are ignored: no entry changes and the write pointer holds.
- R7: `stat_wr` clears `overrun`. If `overrun` was 1, both pointers also return to 0. If `overrun` was 0, `stat_wr` has no effect.
- R8: `cpu_wr` stores `cpu_wdata` at the read-pointer entry and moves neither pointer. If it meets a serial write to the same entry, the CPU byte is kept.
- R9: While `dbg_halt` is 1, CPU read strobes do not advance the read pointer.
- R10: While `enable` is 0, both pointers are 0 on the next edge, serial writes are not stored, and read strobes have no effect.
- R11: `flush` sets both pointers to 0 and drops a same-cycle serial write, while `overrun` keeps its value unless `stat_wr` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low holds the pointers at 0 |
| flush | input | 1 | Low-power entry flush of both pointers |
| ser_wr | input | 1 | Serial-side byte write strobe |
| ser_data | input | WIDTH | Serial-side byte |
| cpu_rd | input | 1 | CPU read strobe of the data port |
| cpu_wr | input | 1 | CPU write strobe of the data port |
| cpu_wdata | input | WIDTH | CPU write byte |
| dbg_halt | input | 1 | Debug halt; freezes read advance |
| stat_wr | input | 1 | Status-register write strobe; clears overrun |
| rd_data | output | WIDTH | Entry at the read pointer |
| not_empty | output | 1 | Buffer holds unread data and no overrun |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Every strobe takes effect at the next rising edge. `rd_data`, `not_empty` and `overrun` are all derived from registers, so their new values are due in the same cycle as that edge. The bench applies each stimulus at a falling edge and samples one time unit after the following rising edge. Its model is updated in that same step, so each compare sees exactly one edge of effect. An entry is compared only after the model has written it, because stored bytes are never reset.

// File: rtl/rx_fifo_ovr_lock.sv
module rx_fifo_ovr_lock #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             flush,
  input  logic             ser_wr,
  input  logic [WIDTH-1:0] ser_data,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [WIDTH-1:0] cpu_wdata,
  input  logic             dbg_halt,
  input  logic             stat_wr,
  output logic [WIDTH-1:0] rd_data,
  output logic             not_empty,
  output logic             overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, wptr_inc, rptr_inc, wptr_nxt, rptr_nxt;
  logic ovr, ovr_nxt;

  wire live   = enable && !flush;
  wire unlock = stat_wr && ovr;
  wire do_wr  = live && ser_wr && !ovr;
  wire do_rd  = live && cpu_rd && !dbg_halt;

  assign wptr_inc = (wptr == LAST) ? '0 : wptr + PW'(1);
  assign rptr_inc = (rptr == LAST) ? '0 : rptr + PW'(1);

  always_comb begin
    rptr_nxt = do_rd ? rptr_inc : rptr;
    wptr_nxt = do_wr ? wptr_inc : wptr;
    if (!live || unlock) begin
      rptr_nxt = '0;
      wptr_nxt = '0;
    end
    if (do_wr && (wptr_inc == rptr_nxt)) ovr_nxt = 1'b1;
    else if (stat_wr)                    ovr_nxt = 1'b0;
    else                                 ovr_nxt = ovr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      ovr  <= 1'b0;
    end else begin
      wptr <= wptr_nxt;
      rptr <= rptr_nxt;
      ovr  <= ovr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr)  mem[wptr] <= ser_data;
    if (cpu_wr) mem[rptr] <= cpu_wdata;
  end

  assign rd_data   = mem[rptr];
  assign overrun   = ovr;
  assign not_empty = (wptr != rptr) && !ovr;

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr <= LAST) && (rptr <= LAST));

  p_ovr_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !stat_wr && live) |=> $stable(wptr));

  p_unlock_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && stat_wr) |=> (wptr == '0) && (rptr == '0) && !ovr);

  p_cpuwr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_rd && !ser_wr && live && !unlock) |=> ($stable(rptr) && $stable(wptr)));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && live && !unlock) |=> $stable(rptr));

  p_disable_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (wptr == '0) && (rptr == '0));

  p_flush_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !stat_wr) |=> (wptr == '0) && (rptr == '0) && (ovr == $past(ovr)));
endmodule

// File: tb/rx_fifo_ovr_lock_tb.sv
module rx_fifo_ovr_lock_tb_top;
  localparam int D = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, flush = 1'b0, ser_wr = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic dbg_halt = 1'b0, stat_wr = 1'b0;
  logic [7:0] ser_data = '0, cpu_wdata = '0;
  logic [7:0] rd_data;
  logic not_empty, overrun;

  rx_fifo_ovr_lock #(.DEPTH(D), .WIDTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush),
    .ser_wr(ser_wr), .ser_data(ser_data), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .dbg_halt(dbg_halt), .stat_wr(stat_wr),
    .rd_data(rd_data), .not_empty(not_empty), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int nvec = 0, nerr = 0;
  int mw = 0, mr = 0;
  bit mo = 1'b0;
  logic [7:0] mm [D];
  bit mk [D];
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic compare(string tag);
    bit ene;
    ene = (mw != mr) && !mo;
    nvec++;
    if (not_empty !== ene || overrun !== mo) begin
      nerr++;
      $display("FAIL %s: flags ne/ovr act=%b/%b exp=%b/%b", tag, not_empty, overrun, ene, mo);
    end
    if (mk[mr]) begin
      nvec++;
      if (rd_data !== mm[mr]) begin
        nerr++;
        $display("FAIL %s: rd_data act=%h exp=%h (entry %0d)", tag, rd_data, mm[mr], mr);
      end
    end
  endtask

  task automatic step(bit sw, logic [7:0] sd, bit rd, bit cw, logic [7:0] cd,
                      bit h, bit st, bit fl, bit en, string tag);
    bit live, unl, dw, dr, no;
    int nw, nr;
    @(negedge clk);
    ser_wr = sw; ser_data = sd; cpu_rd = rd; cpu_wr = cw; cpu_wdata = cd;
    dbg_halt = h; stat_wr = st; flush = fl; enable = en;
    live = en && !fl;
    unl  = st && mo;
    dw   = live && sw && !mo;
    dr   = live && rd && !h;
    nr = dr ? (mr + 1) % D : mr;
    nw = dw ? (mw + 1) % D : mw;
    if (!live || unl) begin nr = 0; nw = 0; end
    no = mo;
    if (dw && nw == nr) no = 1'b1;
    else if (st) no = 1'b0;
    if (dw) begin mm[mw] = sd; mk[mw] = 1'b1; end
    if (cw) begin mm[mr] = cd; mk[mr] = 1'b1; end
    @(posedge clk);
    #1;
    mw = nw; mr = nr; mo = no;
    compare(tag);
  endtask

  task automatic wr(logic [7:0] d, string tag);
    step(1, d, 0, 0, 8'h00, 0, 0, 0, 1, tag);
  endtask

  task automatic rd(string tag);
    step(0, 8'h00, 1, 0, 8'h00, 0, 0, 0, 1, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b1; flush = 1'b0; ser_wr = 1'b0; cpu_rd = 1'b0;
    cpu_wr = 1'b0; dbg_halt = 1'b0; stat_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mw = 0; mr = 0; mo = 1'b0;
    #1;
    nvec++;
    if (not_empty !== 1'b0 || overrun !== 1'b0) begin
      nerr++;
      $display("FAIL R1: reset flags ne/ovr act=%b/%b exp=0/0", not_empty, overrun);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin mk[i] = 1'b0; mm[i] = '0; end
    for (int s = 0; s < D; s++) begin
      do_reset();
      for (int i = 0; i < s; i++) wr(8'(8'h80 + i), "R2");
      for (int i = 0; i < s; i++) rd("R3");
      for (int i = 0; i < D; i++) wr(8'(s * 16 + i), "R5");
      wr(8'hEE, "R6");
      step(0, 8'h00, 1, 0, 8'h00, 1, 0, 0, 1, "R9");
      rd("R3");
      rd("R4");
      step(0, 8'h00, 0, 1, 8'(8'hC0 + s), 0, 0, 0, 1, "R8");
      step(0, 8'h00, 0, 0, 8'h00, 0, 1, 0, 1, "R7");
      step(0, 8'h00, 0, 0, 8'h00, 0, 1, 0, 1, "R7");
      wr(8'(8'h40 + s), "R2");
      step(1, 8'h33, 1, 0, 8'h00, 0, 0, 0, 0, "R10");
      for (int i = 0; i < D; i++) wr(8'(8'h50 + i), "R5");
      step(1, 8'h77, 0, 0, 8'h00, 0, 0, 1, 1, "R11");
      wr(8'h11, "R6");
      step(0, 8'h00, 0, 0, 8'h00, 0, 1, 0, 1, "R7");
      rd("R3");
    end
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      bit en, fl;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      en = lfsr[7:4] != 4'h0;
      fl = lfsr[11:8] == 4'hF;
      step(lfsr[0], lfsr[15:8], lfsr[1] & lfsr[2], lfsr[3] & lfsr[9] & lfsr[12],
           lfsr[7:0], lfsr[13] & lfsr[14], lfsr[5] & lfsr[6] & lfsr[10], fl, en, "R4");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule